// File: doc/BRIEF.md
# Byte-Coded Instruction Sequencer Core

This block is a small multi-cycle processor core. It runs a fixed subset of byte-coded instructions in the style of a classic 8-bit microcontroller. The core reads instruction bytes from a program ROM port: it drives a 16-bit address and takes the byte back in the same cycle. External data stores leave through a separate write port, which carries an address, a data byte and a one-cycle strobe. The architectural state is an 8-bit accumulator, eight 8-bit registers (R0 to R7), a 16-bit data pointer and a 16-bit program counter.

The core has a state machine with seven states. `ST_FETCH` latches the opcode at the program counter and moves to `ST_DECODE`. `ST_DECODE` goes to `ST_HALT` for an opcode it does not implement. Otherwise it goes to `ST_OPND1` when operand bytes follow, or to `ST_EXEC` when none do. `ST_OPND1` moves to `ST_OPND2` when a second operand byte follows, and to `ST_EXEC` when it does not. `ST_OPND2` always moves to `ST_EXEC`. `ST_EXEC` computes the result and the branch decision, then moves to `ST_WB`. `ST_WB` commits the result to its destination and returns to `ST_FETCH`. `ST_HALT` has no exit except reset.

Each operand state and `ST_FETCH` advance the program counter by one.

Top module: `byte_seq_core`

## Requirements
- R1: While the synchronous active-high reset is applied, `rom_addr` is 0000h, `halted` is 0 and `wr_en` is 0. The first opcode after reset is fetched from address 0000h.
- R2: An instruction at address p with n operand bytes takes 4+n cycles, in this order:
  - one cycle at `rom_addr`=p;
  - one decode cycle at p+1;
  - one cycle at p+k for each operand byte k;
  - an execute cycle and a write-back cycle, both at p+1+n;
  - the next fetch.
- R3: Opcode 90h loads the data pointer from the next two bytes, high byte first. The instruction is 3 bytes long.
- R4: Opcodes 78h–7Fh load one immediate byte into register Rn. The register is selected by opcode bits [2:0].
- R5: Opcode F0h writes the accumulator to address = data pointer. `wr_en` is high for exactly one clock, in the write-back cycle.
- R6: Opcode A3h increments the 16-bit data pointer, with the carry passing from the low byte into the high byte.
- R7: Opcodes D8h–DFh decrement Rn (selected by opcode bits [2:0]). When the result is not zero, they branch by a signed 8-bit offset, counted from the address after the 2-byte instruction. A counter starting at 0 wraps to FFh and gives 256 iterations.
- R8: Opcode E4h clears the accumulator. Opcode 04h increments it modulo 256.
- R9: Opcode 80h jumps by a signed 8-bit offset, counted from the address after the 2-byte instruction.
- R10: Opcode A5h halts the core, and so does any other opcode not listed above. After the decode cycle, `halted` is 1 and stays 1, `rom_addr` holds at the halting address plus one, and `wr_en` stays 0.
- R11: Reset clears the accumulator, the data pointer and R0–R7 to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 16 | Program ROM address (the program counter) |
| rom_data | input | 8 | Program ROM byte for `rom_addr`, valid in the same cycle |
| wr_addr | output | 16 | External store address (the data pointer) |
| wr_data | output | 8 | External store data (the accumulator) |
| wr_en | output | 1 | External store strobe, one clock per store |
| halted | output | 1 | High once an unimplemented opcode has been decoded |

## Verification
The bench covers several corner cases, each with the failure it exposes:
- **Data pointer carry.** A pointer stepping from 12FFh to 1300h catches a carry that is lost from the low byte; the store addresses would repeat inside the 12xxh page.
- **Counter preset to 0.** A decrement-and-branch counter preset to 0 must run 256 passes. A design that does not wrap would fall through after one pass, and the fetch addresses would diverge at once.
- **Backward and forward offsets.** These expose a branch computed from the opcode address instead of the next instruction, which shifts every later fetch address.
- **Program run after reset.** A second program runs after a reset, with the pointer and a counter left unset. It shows up a reset that leaves old state behind, through a wrong store address or a loop count that is off.
- **Two halt codes.** A5h and a second unimplemented code both halt the core. This catches a decoder that treats unknown bytes as no-ops and runs on.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam logic [7:0] OPC_LDPTR  = 8'h90;
    localparam logic [7:0] OPC_STORE  = 8'hF0;
    localparam logic [7:0] OPC_INCPTR = 8'hA3;
    localparam logic [7:0] OPC_CLRA   = 8'hE4;
    localparam logic [7:0] OPC_INCA   = 8'h04;
    localparam logic [7:0] OPC_SJMP   = 8'h80;
    localparam logic [4:0] OPC_LDREG_HI = 5'b01111;  // 78h..7Fh
    localparam logic [4:0] OPC_DJNZ_HI  = 5'b11011;  // D8h..DFh

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPND1,
        ST_OPND2,
        ST_EXEC,
        ST_WB,
        ST_HALT
    } state_t;

    typedef enum logic [3:0] {
        K_LDPTR,
        K_LDREG,
        K_STORE,
        K_INCPTR,
        K_DJNZ,
        K_CLRA,
        K_INCA,
        K_SJMP,
        K_BAD
    } opkind_t;

    typedef struct packed {
        opkind_t    kind;
        logic [1:0] nopnd;
        logic [2:0] rsel;
    } dec_t;

endpackage

// File: rtl/bsc_decode.sv
module bsc_decode
    import bsc_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    always_comb begin
        dec.rsel  = opcode[2:0];
        dec.nopnd = 2'd0;
        dec.kind  = K_BAD;
        if (opcode[7:3] == OPC_LDREG_HI) begin
            dec.kind  = K_LDREG;
            dec.nopnd = 2'd1;
        end else if (opcode[7:3] == OPC_DJNZ_HI) begin
            dec.kind  = K_DJNZ;
            dec.nopnd = 2'd1;
        end else begin
            unique case (opcode)
                OPC_LDPTR: begin
                    dec.kind  = K_LDPTR;
                    dec.nopnd = 2'd2;
                end
                OPC_STORE:  dec.kind = K_STORE;
                OPC_INCPTR: dec.kind = K_INCPTR;
                OPC_CLRA:   dec.kind = K_CLRA;
                OPC_INCA:   dec.kind = K_INCA;
                OPC_SJMP: begin
                    dec.kind  = K_SJMP;
                    dec.nopnd = 2'd1;
                end
                default:    dec.kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/bsc_regfile.sv
module bsc_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && sel == SW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[sel];

    // R4: a write lands in the selected register
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(sel)] == $past(wdata));

endmodule

// File: rtl/bsc_ptr.sv
module bsc_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (inc)
            ptr <= ptr + AW'(1);
    end

    // R6: increment carries across the full width
    a_r6_inc_carry: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> ptr == $past(ptr) + AW'(1));

    // R3: a load takes the assembled value
    a_r3_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr == $past(load_val));

endmodule

// File: rtl/byte_seq_core.sv
module byte_seq_core
    import bsc_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_data,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_en,
    output logic          halted
);

    state_t        state, state_nx;
    logic [AW-1:0] pc;
    logic [DW-1:0] opc, op1, op2, acc, res_q;
    logic          take_q;
    dec_t          dec;
    logic [DW-1:0] rn;
    logic [DW-1:0] rn_dec;
    logic [AW-1:0] dptr;
    logic          reg_we, ptr_load, ptr_inc, in_wb;

    bsc_decode u_dec (
        .opcode (opc),
        .dec    (dec)
    );

    assign in_wb  = (state == ST_WB);
    assign reg_we = in_wb && (dec.kind == K_LDREG || dec.kind == K_DJNZ);
    assign ptr_load = in_wb && dec.kind == K_LDPTR;
    assign ptr_inc  = in_wb && dec.kind == K_INCPTR;
    assign rn_dec   = rn - DW'(1);

    bsc_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (dec.rsel[SW-1:0]),
        .wdata (res_q),
        .rdata (rn)
    );

    bsc_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (AW'({op1, op2})),
        .inc      (ptr_inc),
        .ptr      (dptr)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: begin
                if (dec.kind == K_BAD)    state_nx = ST_HALT;
                else if (dec.nopnd != 0)  state_nx = ST_OPND1;
                else                      state_nx = ST_EXEC;
            end
            ST_OPND1:  state_nx = (dec.nopnd == 2'd2) ? ST_OPND2 : ST_EXEC;
            ST_OPND2:  state_nx = ST_EXEC;
            ST_EXEC:   state_nx = ST_WB;
            ST_WB:     state_nx = ST_FETCH;
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            opc    <= '0;
            op1    <= '0;
            op2    <= '0;
            acc    <= '0;
            res_q  <= '0;
            take_q <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    opc <= rom_data;
                    pc  <= pc + AW'(1);
                end
                ST_OPND1: begin
                    op1 <= rom_data;
                    pc  <= pc + AW'(1);
                end
                ST_OPND2: begin
                    op2 <= rom_data;
                    pc  <= pc + AW'(1);
                end
                ST_EXEC: begin
                    unique case (dec.kind)
                        K_LDREG: res_q <= op1;
                        K_DJNZ:  res_q <= rn_dec;
                        K_CLRA:  res_q <= '0;
                        K_INCA:  res_q <= acc + DW'(1);
                        default: res_q <= acc;
                    endcase
                    take_q <= (dec.kind == K_SJMP) ||
                              (dec.kind == K_DJNZ && rn_dec != '0);
                end
                ST_WB: begin
                    if (dec.kind == K_CLRA || dec.kind == K_INCA)
                        acc <= res_q;
                    if (take_q)
                        pc <= pc + {{(AW-DW){op1[DW-1]}}, op1};
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rom_addr = pc;
        wr_addr  = dptr;
        wr_data  = acc;
        wr_en    = in_wb && dec.kind == K_STORE;
        halted   = (state == ST_HALT);
    end

    // R5: store strobe lasts one clock
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R10: halt is sticky, freezes fetch address, blocks stores
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(rom_addr));
    a_r10_no_store: assert property (@(posedge clk) disable iff (rst)
        halted |-> !wr_en);

    // R2: write-back always returns to fetch; operand cycles step the address
    a_r2_wb_to_fetch: assert property (@(posedge clk) disable iff (rst)
        state == ST_WB |=> state == ST_FETCH);
    a_r2_opnd_step: assert property (@(posedge clk) disable iff (rst)
        state == ST_OPND1 |=> rom_addr == $past(rom_addr) + AW'(1));

endmodule

// File: tb/sim_byte_seq_core.sv
`timescale 1ns/1ps
module sim_byte_seq_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rom_addr;
    logic [7:0]  rom_data;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_en;
    logic        halted;

    logic [7:0] rom [256];
    int vectors = 0;
    int miscompares = 0;

    int    q_addr[$];
    bit    q_en[$];
    int    q_wa[$];
    int    q_wd[$];
    bit    q_halt[$];
    string q_tag[$];

    always #2 clk = ~clk;

    assign rom_data = (rom_addr < 16'd256) ? rom[rom_addr[7:0]] : 8'hA5;

    byte_seq_core u0 (
        .clk      (clk),
        .rst      (rst),
        .rom_addr (rom_addr),
        .rom_data (rom_data),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .halted   (halted)
    );

    function automatic int rom_at(int a);
        return (a < 256) ? int'(rom[a]) : 32'hA5;
    endfunction

    task automatic push(int a, bit en, int wa, int wd, bit h, string tag);
        q_addr.push_back(a & 16'hFFFF);
        q_en.push_back(en);
        q_wa.push_back(wa & 16'hFFFF);
        q_wd.push_back(wd & 8'hFF);
        q_halt.push_back(h);
        q_tag.push_back(tag);
    endtask

    // behavioural reference: runs the program and lists expected per-cycle outputs
    task automatic model();
        int pc = 0, acc = 0, dp = 0;
        int r[8];
        bit done = 0;
        int guard = 0;
        int op, n, b1, b2, off;
        bit legal;
        string tag;
        foreach (r[i]) r[i] = 0;          // R11: reset clears registers
        while (!done && guard < 20000) begin
            guard++;
            op = rom_at(pc);
            b1 = rom_at((pc + 1) & 16'hFFFF);
            b2 = rom_at((pc + 2) & 16'hFFFF);
            legal = 1; n = 0; tag = "R10";
            if (op >= 8'h78 && op <= 8'h7F) begin n = 1; tag = "R4"; end
            else if (op >= 8'hD8 && op <= 8'hDF) begin n = 1; tag = "R7"; end
            else if (op == 8'h90) begin n = 2; tag = "R3"; end
            else if (op == 8'hF0) tag = "R5";
            else if (op == 8'hA3) tag = "R6";
            else if (op == 8'hE4 || op == 8'h04) tag = "R8";
            else if (op == 8'h80) begin n = 1; tag = "R9"; end
            else legal = 0;
            push(pc, 0, 0, 0, 0, tag);          // fetch
            push(pc + 1, 0, 0, 0, 0, tag);      // decode
            if (!legal) begin
                for (int k = 0; k < 6; k++) push(pc + 1, 0, 0, 0, 1, "R10");
                done = 1;
            end else begin
                for (int k = 1; k <= n; k++) push(pc + k, 0, 0, 0, 0, tag);
                push(pc + 1 + n, 0, 0, 0, 0, tag);                  // execute
                push(pc + 1 + n, op == 8'hF0, dp, acc, 0, tag);     // write-back
                pc = (pc + 1 + n) & 16'hFFFF;
                off = (b1 >= 128) ? b1 - 256 : b1;
                if (op >= 8'h78 && op <= 8'h7F) r[op & 7] = b1;
                else if (op >= 8'hD8 && op <= 8'hDF) begin
                    r[op & 7] = (r[op & 7] - 1) & 8'hFF;
                    if (r[op & 7] != 0) pc = (pc + off) & 16'hFFFF;
                end
                else if (op == 8'h90) dp = (b1 << 8) | b2;
                else if (op == 8'hA3) dp = (dp + 1) & 16'hFFFF;
                else if (op == 8'hE4) acc = 0;
                else if (op == 8'h04) acc = (acc + 1) & 8'hFF;
                else if (op == 8'h80) pc = (pc + off) & 16'hFFFF;
            end
        end
    endtask

    task automatic fail_line(string what, string tag, int act, int exp);
        miscompares++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    endtask

    task automatic run_program();
        // R1: reset state
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        vectors++;
        if (rom_addr !== 16'h0000 || halted !== 1'b0 || wr_en !== 1'b0)
            fail_line("reset state", "R1", {rom_addr, 7'b0, halted, wr_en}, 0);
        model();
        @(negedge clk);
        rst = 1'b0;
        #1;
        while (q_addr.size() > 0) begin
            int    ea = q_addr.pop_front();
            bit    ee = q_en.pop_front();
            int    ew = q_wa.pop_front();
            int    ed = q_wd.pop_front();
            bit    eh = q_halt.pop_front();
            string tg = q_tag.pop_front();
            vectors++;
            if (int'(rom_addr) != ea) fail_line("rom_addr (R2 timing)", tg, rom_addr, ea);
            if (halted !== eh)        fail_line("halted", tg, halted, eh);
            if (wr_en !== ee)         fail_line("wr_en", tg, wr_en, ee);
            if (ee && wr_en) begin
                if (int'(wr_addr) != ew) fail_line("wr_addr", tg, wr_addr, ew);
                if (int'(wr_data) != ed) fail_line("wr_data", tg, wr_data, ed);
            end
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clear_rom();
        foreach (rom[i]) rom[i] = 8'hA5;
    endtask

    initial begin
        // P1: pointer load, carry across 12FFh, 3-pass counted store loop (R3 R4 R5 R6 R7 R8)
        clear_rom();
        rom[0] = 8'h90; rom[1] = 8'h12; rom[2] = 8'hFF;
        rom[3] = 8'h7A; rom[4] = 8'h03;
        rom[5] = 8'hE4; rom[6] = 8'h04;
        rom[7] = 8'hF0; rom[8] = 8'hA3; rom[9] = 8'h04;
        rom[10] = 8'hDA; rom[11] = 8'hFB;
        rom[12] = 8'hA5;
        run_program();

        // P2: counter preset 0 gives 256 passes; forward short jump; other halt code (R7 R9 R10)
        clear_rom();
        rom[0] = 8'hE4;
        rom[1] = 8'h7B; rom[2] = 8'h00;
        rom[3] = 8'hA3;
        rom[4] = 8'hDB; rom[5] = 8'hFD;
        rom[6] = 8'hF0;
        rom[7] = 8'h80; rom[8] = 8'h02;
        rom[9] = 8'h04; rom[10] = 8'h04;
        rom[11] = 8'hF0;
        rom[12] = 8'h01;
        run_program();

        // P3: register select by low bits, self-loop branch, fall-through; pointer cleared (R4 R7 R11)
        clear_rom();
        rom[0] = 8'h78; rom[1] = 8'h01;
        rom[2] = 8'h7D; rom[3] = 8'h02;
        rom[4] = 8'h04;
        rom[5] = 8'hDD; rom[6] = 8'hFE;
        rom[7] = 8'hD8; rom[8] = 8'h02;
        rom[9] = 8'hF0;
        rom[10] = 8'h7C; rom[11] = 8'h05;
        rom[12] = 8'hA5;
        run_program();

        // P4: R4 left at 5 by P3 must be cleared by reset -> 256 passes (R11)
        clear_rom();
        rom[0] = 8'h04;
        rom[1] = 8'hDC; rom[2] = 8'hFE;
        rom[3] = 8'hF0;
        rom[4] = 8'hA5;
        run_program();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule